// File: doc/BRIEF.md
# Flash Program Write Controller

This block sequences erase and program operations on a small on-chip program flash array. Software reaches it through a byte-wide register port. A 22-bit table pointer and an 8-bit data latch feed a table-write strobe. Each strobe places the latch byte into one of 64 staging bytes, chosen by the low six pointer bits. The pointer can advance by one after each strobe.

When the staging row is ready, software sets the write-enable bit. It then writes the control register with the start bit set, and the erase-select bit picks the kind of operation. A programming timer then runs for a fixed number of clocks. At the end, the row chosen by the pointer bits above bit 5 is either filled with 0xFF (erase) or loaded with the staging bytes (program). The start bit clears itself. An error flag shows an operation that was refused or cut short by a reset. A dummy unlock register accepts writes and always reads zero. A read port on the array lets its contents be observed.

Top module: `flash_prog_ctrl`

## Requirements
- R1: A table-write strobe stores the latch byte into staging entry `pointer[5:0]`. With the increment input high, the pointer then advances by one and wraps from 0x3FFFFF to 0. With the increment input low, the pointer is unchanged.
- R2: With write-enable already set, a control write of start=1 (bit 0) and erase-select=0 (bit 2) runs a program operation. At completion the array row `pointer[6 +: ROW_AW]` (pointer value at start) holds the staging bytes, and all staging entries return to 0xFF.
- R3: The same start with erase-select=1 fills the addressed 64-byte row with 0xFF.
- R4: The start bit (control bit 0) reads 1 for exactly PROG_CYCLES clocks after an accepted start. Writing 0 to it has no effect, and hardware clears it at completion.
- R5: The error flag (control bit 3, read-only) is set when a start is accepted and cleared at normal completion.
- R6: A start written while write-enable (control bit 1) is clear is refused: no operation begins, the array is not changed, and the error flag reads 1.
- R7: After reset, write-enable and erase-select read 0 and the busy output is low.
- R8: A reset asserted while an operation runs ends it without changing the array, and the error flag reads 1 afterwards.
- R9: The unlock register (address 1) always reads 0x00, even after a write to it.
- R10: Control writes made while busy leave write-enable and erase-select unchanged.
- R11: Table-write strobes made while busy change neither the pointer nor the staging entries.
- R12: Register map: 0 control, 1 unlock, 2 latch, 3/4/5 pointer bits [7:0]/[15:8]/[21:16]. After reset the latch and the pointer read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| tbl_wr | input | 1 | Table-write strobe: latch byte into staging entry |
| tbl_inc | input | 1 | Post-increment the pointer with the strobe |
| busy | output | 1 | Programming operation in progress |
| fl_raddr | input | ROW_AW+6 | Array read address |
| fl_rdata | output | 8 | Array byte at fl_raddr |

## Verification
A timer count that is off by even one clock shows on the busy output and on the start bit on the first completion, as a window longer or shorter than PROG_CYCLES. A mode or row that was latched wrongly, or a staging buffer left dirty, only appears once the operation ends. It shows as the wrong bytes on the array read port, so each commit is followed by a read of the whole row and of a second row that the erased buffer must fill. A lost error flag after a refused start or an aborted run is visible on the next control read.

// File: rtl/fpw_pkg.sv
// Shared constants for the flash program write controller.
// Assumes a byte-wide register port with a 3-bit address.
package fpw_pkg;
    localparam int PTR_W    = 22;
    localparam int BUF_AW   = 6;
    localparam int BUF_DEPTH = 1 << BUF_AW;
    localparam int BYTE_W   = 8;

    typedef enum logic [2:0] {
        RA_CTRL    = 3'd0,
        RA_UNLOCK  = 3'd1,
        RA_LATCH   = 3'd2,
        RA_PTR_LO  = 3'd3,
        RA_PTR_MID = 3'd4,
        RA_PTR_HI  = 3'd5
    } reg_addr_e;

    localparam int CB_GO    = 0;
    localparam int CB_WEN   = 1;
    localparam int CB_ERASE = 2;
    localparam int CB_ERR   = 3;
endpackage

// File: rtl/fpw_hold_buf.sv
// Staging buffer: DEPTH byte entries written one at a time and cleared
// to 0xFF all at once. Assumes the caller blocks writes while busy.
module fpw_hold_buf #(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_idx,
    input  logic [7:0]           wr_data,
    input  logic                 clear,
    output logic [DEPTH*8-1:0]   flat
);
    logic [7:0] entry_q [DEPTH];

    // Entry update: reset or clear fills with 0xFF, else single-byte store.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int i = 0; i < DEPTH; i++) entry_q[i] <= 8'hFF;
        end else if (wr_en) begin
            entry_q[wr_idx] <= wr_data;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign flat[g*8 +: 8] = entry_q[g];
    end
endmodule

// File: rtl/fpw_prog_timer.sv
// Programming timer: once launched it stays active for exactly CYCLES
// clocks, and pulses done in the last of them. A launch while active is ignored.
module fpw_prog_timer #(
    parameter int CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic active,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic          run_q = 1'b0;
    logic [CW-1:0] cnt_q;

    assign active = run_q;
    assign done   = run_q && (cnt_q == '0);

    // Countdown: load on launch, decrement while running, stop on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (launch && !run_q) begin
            run_q <= 1'b1;
            cnt_q <= CW'(CYCLES - 1);
        end else if (done) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/fpw_flash_array.sv
// Behavioural program flash: 2**ROW_AW rows of ROW_BYTES bytes. A commit
// erases or loads one whole row in one clock. Contents are not reset.
module fpw_flash_array #(
    parameter int ROW_AW  = 4,
    parameter int BYTE_AW = 6
) (
    input  logic                          clk,
    input  logic                          commit,
    input  logic                          erase,
    input  logic [ROW_AW-1:0]             row,
    input  logic [(1<<BYTE_AW)*8-1:0]     row_data,
    input  logic [ROW_AW+BYTE_AW-1:0]     rd_addr,
    output logic [7:0]                    rd_data
);
    localparam int ROW_BYTES = 1 << BYTE_AW;
    localparam int WORDS     = 1 << (ROW_AW + BYTE_AW);

    logic [7:0] cell_q [WORDS];

    // Row commit: every byte of the selected row is replaced at once.
    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < ROW_BYTES; i++) begin
                cell_q[{row, BYTE_AW'(i)}] <= erase ? 8'hFF : row_data[i*8 +: 8];
            end
        end
    end

    assign rd_data = cell_q[rd_addr];
endmodule

// File: rtl/flash_prog_ctrl.sv
// Flash program write controller top. Holds the control, latch and pointer
// registers, and launches the timer. At the end of the run it commits an
// erase or a program to the array. Assumes one register access per clock.
module flash_prog_ctrl
    import fpw_pkg::*;
#(
    parameter int PROG_CYCLES = 1024,
    parameter int ROW_AW      = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [2:0]              reg_addr,
    input  logic [7:0]              reg_wdata,
    output logic [7:0]              reg_rdata,
    input  logic                    tbl_wr,
    input  logic                    tbl_inc,
    output logic                    busy,
    input  logic [ROW_AW+5:0]       fl_raddr,
    output logic [7:0]              fl_rdata
);
    localparam int ROW_LSB = BUF_AW;

    logic              wen_q;
    logic              erase_q;
    logic              err_q = 1'b0;
    logic              mode_erase_q;
    logic [ROW_AW-1:0] row_q;
    logic [7:0]        latch_q;
    logic [PTR_W-1:0]  ptr_q;

    logic              prog_done;
    logic              ctrl_wr;
    logic              go_req;
    logic              launch;
    logic              stage_wr;
    logic [BUF_DEPTH*8-1:0] stage_flat;

    assign ctrl_wr  = reg_wr && (reg_addr == RA_CTRL);
    assign go_req   = ctrl_wr && reg_wdata[CB_GO] && !busy;
    assign launch   = go_req && wen_q;
    assign stage_wr = tbl_wr && !busy;

    // Control state: mode bits, latched operation, and the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_q   <= 1'b0;
            erase_q <= 1'b0;
            err_q   <= err_q | busy;
        end else begin
            if (ctrl_wr && !busy) begin
                wen_q   <= reg_wdata[CB_WEN];
                erase_q <= reg_wdata[CB_ERASE];
            end
            if (go_req) begin
                err_q <= 1'b1;
            end else if (prog_done) begin
                err_q <= 1'b0;
            end
        end
    end

    // Operation capture: mode and target row are frozen at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_erase_q <= 1'b0;
            row_q        <= '0;
        end else if (launch) begin
            mode_erase_q <= reg_wdata[CB_ERASE];
            row_q        <= ptr_q[ROW_LSB +: ROW_AW];
        end
    end

    // Data path registers: latch byte and table pointer with post-increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            ptr_q   <= '0;
        end else begin
            if (stage_wr && tbl_inc) begin
                ptr_q <= ptr_q + 1'b1;
            end
            if (reg_wr) begin
                case (reg_addr)
                    RA_LATCH:   latch_q        <= reg_wdata;
                    RA_PTR_LO:  ptr_q[7:0]     <= reg_wdata;
                    RA_PTR_MID: ptr_q[15:8]    <= reg_wdata;
                    RA_PTR_HI:  ptr_q[21:16]   <= reg_wdata[5:0];
                    default: ;
                endcase
            end
        end
    end

    // Register read mux; the unlock address has no storage behind it.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CB_GO]    = busy;
                reg_rdata[CB_WEN]   = wen_q;
                reg_rdata[CB_ERASE] = erase_q;
                reg_rdata[CB_ERR]   = err_q;
            end
            RA_LATCH:   reg_rdata = latch_q;
            RA_PTR_LO:  reg_rdata = ptr_q[7:0];
            RA_PTR_MID: reg_rdata = ptr_q[15:8];
            RA_PTR_HI:  reg_rdata = {2'b00, ptr_q[21:16]};
            default:    reg_rdata = '0;
        endcase
    end

    fpw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .active (busy),
        .done   (prog_done)
    );

    fpw_hold_buf #(.DEPTH(BUF_DEPTH), .AW(BUF_AW)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (stage_wr),
        .wr_idx  (ptr_q[BUF_AW-1:0]),
        .wr_data (latch_q),
        .clear   (prog_done && !mode_erase_q),
        .flat    (stage_flat)
    );

    fpw_flash_array #(.ROW_AW(ROW_AW), .BYTE_AW(BUF_AW)) u_array (
        .clk      (clk),
        .commit   (prog_done),
        .erase    (mode_erase_q),
        .row      (row_q),
        .row_data (stage_flat),
        .rd_addr  (fl_raddr),
        .rd_data  (fl_rdata)
    );
endmodule

// File: rtl/flash_prog_ctrl_chk.sv
// Property checker for flash_prog_ctrl, attached by bind below.
module flash_prog_ctrl_chk #(
    parameter int PTR_W = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic [7:0]       reg_wdata,
    input logic [7:0]       reg_rdata,
    input logic             tbl_wr,
    input logic             busy,
    input logic             done,
    input logic             wen,
    input logic             erase,
    input logic             err,
    input logic [PTR_W-1:0] ptr
);
    a_r4_start_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r4_clear_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r5_err_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> err);

    a_r5_err_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !err);

    a_r6_locked_start: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && reg_wdata[0] && !wen && !busy) |=> (!busy && err));

    a_r9_unlock_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd1) |-> (reg_rdata == 8'h00));

    a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(wen) && $stable(erase)));

    a_r11_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tbl_wr && !reg_wr) |=> $stable(ptr));
endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk #(.PTR_W(22)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tbl_wr    (tbl_wr),
    .busy      (busy),
    .done      (prog_done),
    .wen       (wen_q),
    .erase     (erase_q),
    .err       (err_q),
    .ptr       (ptr_q)
);

// File: tb/flash_prog_ctrl_tb.sv
// Directed bench for flash_prog_ctrl: one task per scenario.
module flash_prog_ctrl_tb;
    localparam int PROG = 1024;
    localparam int RAW  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [2:0]       reg_addr = 3'd7;
    logic [7:0]       reg_wdata = '0;
    logic [7:0]       reg_rdata;
    logic             tbl_wr = 1'b0;
    logic             tbl_inc = 1'b0;
    logic             busy;
    logic [RAW+5:0]   fl_raddr = '0;
    logic [7:0]       fl_rdata;

    int n_chk = 0;
    int n_bad = 0;

    flash_prog_ctrl #(.PROG_CYCLES(PROG), .ROW_AW(RAW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tbl_wr(tbl_wr),
        .tbl_inc(tbl_inc), .busy(busy), .fl_raddr(fl_raddr), .fl_rdata(fl_rdata)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'd7;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 3'd7;
    endtask

    task automatic read_ptr(output logic [21:0] p);
        logic [7:0] b0, b1, b2;
        reg_read(3'd3, b0); reg_read(3'd4, b1); reg_read(3'd5, b2);
        p = {b2[5:0], b1, b0};
    endtask

    task automatic set_ptr(input logic [21:0] p);
        reg_write(3'd3, p[7:0]); reg_write(3'd4, p[15:8]); reg_write(3'd5, {2'b00, p[21:16]});
    endtask

    task automatic tbl_write(input logic [7:0] d, input logic inc);
        reg_write(3'd2, d);
        tbl_wr = 1'b1; tbl_inc = inc;
        @(posedge clk);
        @(negedge clk);
        tbl_wr = 1'b0; tbl_inc = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 3) & 8'hFF);
    endfunction

    task automatic check_row(input string req, input int row, input bit use_pat, input logic [7:0] fill);
        int bad = 0;
        for (int i = 0; i < 64; i++) begin
            fl_raddr = (RAW + 6)'(row * 64 + i);
            #1;
            if (fl_rdata !== (use_pat ? pat(i) : fill)) begin
                if (bad == 0) check(req, fl_rdata, use_pat ? pat(i) : fill);
                bad++;
            end
        end
        if (bad == 0) check(req, 0, 0);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        logic [21:0] p;
        reg_read(3'd0, d); check("R7 control after reset", d, 8'h00);
        check("R7 busy after reset", busy, 0);
        read_ptr(p);       check("R12 pointer after reset", p, 0);
        reg_read(3'd2, d); check("R12 latch after reset", d, 8'h00);
    endtask

    task automatic t_unlock();
        logic [7:0] d;
        reg_write(3'd1, 8'hA5);
        reg_read(3'd1, d); check("R9 unlock reads zero", d, 8'h00);
    endtask

    task automatic t_locked_start();
        logic [7:0] d;
        reg_write(3'd0, 8'h01);
        check("R6 no busy without enable", busy, 0);
        repeat (5) @(negedge clk);
        check("R6 still idle", busy, 0);
        reg_read(3'd0, d); check("R6 error flag set, start clear", d, 8'h08);
    endtask

    task automatic t_erase();
        logic [7:0] d;
        int n = 0;
        set_ptr(22'h0000C0);
        reg_write(3'd0, 8'h02);
        reg_write(3'd0, 8'h07);
        reg_read(3'd0, d); check("R5 error set and start reads 1", d, 8'h0F);
        while (busy && n < 5000) begin n++; @(negedge clk); end
        check("R4 busy window length", n, PROG);
        reg_read(3'd0, d); check("R5 start and error cleared at completion", d, 8'h06);
        check_row("R3 erased row is all ones", 3, 0, 8'hFF);
    endtask

    task automatic t_write();
        logic [7:0] d;
        logic [21:0] p;
        set_ptr(22'h000140);
        tbl_write(8'h11, 1'b0);
        read_ptr(p); check("R1 no increment without inc", p, 22'h000140);
        for (int i = 0; i < 64; i++) tbl_write(pat(i), 1'b1);
        read_ptr(p); check("R1 pointer advanced by 64", p, 22'h000180);
        set_ptr(22'h000140);
        reg_write(3'd0, 8'h02);
        reg_write(3'd0, 8'h03);
        reg_write(3'd0, 8'h04);
        reg_read(3'd0, d); check("R4 R10 start not cleared, mode kept", d, 8'h0B);
        tbl_write(8'h55, 1'b1);
        read_ptr(p); check("R11 pointer frozen while busy", p, 22'h000140);
        wait_idle();
        check_row("R2 row holds staged bytes", 5, 1, 8'h00);
        set_ptr(22'h000180);
        reg_write(3'd0, 8'h03);
        wait_idle();
        check_row("R2 R11 staging reset to all ones", 6, 0, 8'hFF);
    endtask

    task automatic t_wrap();
        logic [21:0] p;
        set_ptr(22'h3FFFFF);
        tbl_write(8'h77, 1'b1);
        read_ptr(p); check("R1 pointer wraps to zero", p, 22'h000000);
    endtask

    task automatic t_abort();
        logic [7:0] d;
        set_ptr(22'h000140);
        reg_write(3'd0, 8'h02);
        reg_write(3'd0, 8'h07);
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 busy dropped by reset", busy, 0);
        reg_read(3'd0, d); check("R8 error flag after abort", d, 8'h08);
        repeat (PROG + 10) @(negedge clk);
        check_row("R8 row untouched by aborted erase", 5, 1, 8'h00);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unlock();
        t_locked_start();
        t_erase();
        t_write();
        t_wrap();
        t_abort();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule